// File: doc/BRIEF.md
# Timer Event Flag Register

This block gathers the event flags of three timer channels into one 16-bit status word. Each channel brings a counter-wrap strobe and, for each of its four general registers, a capture strobe, a counter-equals-register strobe and a 2-bit mode. Whether a strobe counts as an event depends on that register's mode. A qualifying event sets a sticky flag.

Software reads the word through a simple read/write port. A flag can be cleared only by a read that returns it as 1, followed by a write of 0 to that bit. Any other write has no effect on the flag. Writing 1 never sets a flag. When a set event and a clearing write hit the same flag in the same cycle, the set wins.

An interrupt request line carries the OR of all flags, registered once. The block contains no counters, no comparators and no capture datapaths. It only records their strobes.

Top module: `tmr_event_flags`

## Requirements
- R1: After reset every flag reads 0 and `irq` is 0.
- R2: The layout of `rd_data` for channel c (c = 0, 1, 2) is as follows. Bit 5c+4 is the channel's wrap flag. Bits 5c+3 down to 5c+0 are the flags of general registers 3 down to 0. Bit 15 always reads 0, and writing it has no effect.
- R3: A one-cycle pulse on `wrap_pulse[c]` sets the wrap flag of channel c. The flag is visible on `rd_data` in the cycle after the pulse.
- R4: In capture mode (mode code 2'b00), a pulse on `cap_pulse[4c+g]` sets the flag of register g of channel c. A match pulse in this mode is ignored.
- R5: In compare mode (mode code 2'b01), a pulse on `match_pulse[4c+g]` sets the flag. A capture pulse in this mode is ignored.
- R6: In PWM-cycle mode (mode code 2'b10), a match pulse sets the flag and a capture pulse is ignored. In the idle code 2'b11, no strobe sets the flag. The mode of register 4c+g sits at `gr_mode[2(4c+g)+1 : 2(4c+g)]`.
- R7: Flags are sticky. A write of 1 to any flag bit neither sets nor clears it.
- R8: A write of 0 clears a flag only if an earlier read returned that flag as 1. A bit that read as 0, or that was never read, keeps its value when written 0.
- R9: Every write consumes the read arming of all bits. After any write, a further write of 0 clears nothing until a new read.
- R10: If a set event and a clearing write reach the same flag in the same cycle, the flag stays 1.
- R11: `irq` equals the OR of all flags one cycle earlier.
- R12: `rd_data` shows the current flags in the same cycle, without a register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrap_pulse | input | 3 | Counter-wrap strobe, one per channel |
| cap_pulse | input | 12 | Capture strobe per general register, index 4c+g |
| match_pulse | input | 12 | Counter-equals-register strobe per general register |
| gr_mode | input | 24 | 2-bit mode per general register |
| rd_en | input | 1 | Read strobe; arms each bit that reads 1 |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data; 0 on an armed bit clears it |
| rd_data | output | 16 | Current flag word |
| irq | output | 1 | Registered OR of all flags |

## Verification
On every cycle, the assertions check the properties local to a single flag:
- a set event leaves the flag at 1;
- a flag never falls without an armed write of 0;
- an unarmed flag holds;
- a write leaves every arm consumed;
- `irq` tracks the previous OR of the flags.

Only the bench's scenarios can show the properties that span the whole word and longer command sequences:
- the bit placement of each channel and register;
- that a strobe in the wrong mode is ignored;
- that a read of a 0 arms nothing;
- the read, write, write ordering that shows a write consumes the arms.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  typedef enum logic [1:0] {
    GR_CAPTURE   = 2'b00,
    GR_COMPARE   = 2'b01,
    GR_PWM_CYCLE = 2'b10,
    GR_IDLE      = 2'b11
  } gr_mode_e;

  // Position of general-register flag g of channel ch in the status word.
  function automatic int unsigned gr_flag_pos(int unsigned ch, int unsigned g,
                                              int unsigned per_ch);
    return ch * per_ch + g;
  endfunction

  // Position of the wrap flag of channel ch (top slot of its group).
  function automatic int unsigned wrap_flag_pos(int unsigned ch, int unsigned per_ch);
    return ch * per_ch + (per_ch - 1);
  endfunction

  // Does a strobe pair count as an event under the given mode?
  function automatic logic gr_event_hit(gr_mode_e m, logic cap, logic match);
    case (m)
      GR_CAPTURE:   return cap;
      GR_COMPARE:   return match;
      GR_PWM_CYCLE: return match;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tsf_event_decode.sv
module tsf_event_decode
  import tsf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       cap_i,
  input  logic       match_i,
  output logic       set_o
);

  gr_mode_e mode;

  always_comb begin
    mode  = gr_mode_e'(mode_i);
    set_o = gr_event_hit(mode, cap_i, match_i);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |-> !set_o); // R6
  AST_CAPTURE_IGNORES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && !cap_i) |-> !set_o); // R4
  AST_COMPARE_IGNORES_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[1] != mode_i[0] && !match_i) |-> !set_o); // R5

endmodule

// File: rtl/tsf_flag_cell.sv
module tsf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  output logic flag_o
);

  logic flag_q, arm_q;
  logic clear_hit;

  assign clear_hit = wr_i && arm_q && !wr_bit_i;
  assign flag_o    = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= set_i | (flag_q & ~clear_hit);
      if (wr_i)      arm_q <= 1'b0;
      else if (rd_i) arm_q <= arm_q | flag_q;
    end
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q); // R10
  AST_UNARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !arm_q) |=> flag_q); // R8
  AST_FALL_NEEDS_ARMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wr_i && arm_q && !wr_bit_i)); // R8
  AST_WRITE_EATS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !arm_q); // R9
  AST_ONE_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && wr_i && wr_bit_i) |=> flag_q); // R7

endmodule

// File: rtl/tsf_flag_bank.sv
module tsf_flag_bank #(
  parameter int unsigned N = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         rd_en,
  input  logic         wr_en,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_cell
    tsf_flag_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_vec[i]),
      .rd_i     (rd_en),
      .wr_i     (wr_en),
      .wr_bit_i (wr_bits[i]),
      .flag_o   (flags[i])
    );
  end

endmodule

// File: rtl/tmr_event_flags.sv
module tmr_event_flags
  import tsf_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned NUM_GR = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned PER_CH = NUM_GR + 1,
  localparam int unsigned FLAG_N = NUM_CH * PER_CH,
  localparam int unsigned GR_N   = NUM_CH * NUM_GR
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   wrap_pulse,
  input  logic [GR_N-1:0]     cap_pulse,
  input  logic [GR_N-1:0]     match_pulse,
  input  logic [2*GR_N-1:0]   gr_mode,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq
);

  logic [FLAG_N-1:0] set_vec;
  logic [FLAG_N-1:0] flags;
  logic              any_flag;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign set_vec[wrap_flag_pos(c, PER_CH)] = wrap_pulse[c];
    for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
      localparam int unsigned IDX = c * NUM_GR + g;
      tsf_event_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (gr_mode[2*IDX +: 2]),
        .cap_i   (cap_pulse[IDX]),
        .match_i (match_pulse[IDX]),
        .set_o   (set_vec[gr_flag_pos(c, g, PER_CH)])
      );
    end
  end

  tsf_flag_bank #(.N(FLAG_N)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_bits (wr_data[FLAG_N-1:0]),
    .flags   (flags)
  );

  assign any_flag = |flags;

  always_comb begin
    rd_data             = '0;
    rd_data[FLAG_N-1:0] = flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_flag;
  end

  AST_IRQ_LAGS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(any_flag))); // R11
  AST_RESERVED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && |wr_data[DATA_W-1:FLAG_N]) |=> (rd_data[DATA_W-1:FLAG_N] == '0)); // R2
  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse[0] |=> rd_data[wrap_flag_pos(0, PER_CH)]); // R3

endmodule

// File: tb/tmr_event_flags_test.sv
`timescale 1ns/1ps
module tmr_event_flags_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  wrap_pulse = '0;
  logic [11:0] cap_pulse = '0;
  logic [11:0] match_pulse = '0;
  logic [23:0] gr_mode = '1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  tmr_event_flags uut (
    .clk(clk), .rst_n(rst_n), .wrap_pulse(wrap_pulse), .cap_pulse(cap_pulse),
    .match_pulse(match_pulse), .gr_mode(gr_mode), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  function automatic int gr_bit(int ch, int g);
    return 5 * ch + g;
  endfunction

  function automatic int wrap_bit(int ch);
    return 5 * ch + 4;
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_mode(int ch, int g, logic [1:0] m);
    gr_mode[2*(4*ch+g) +: 2] = m;
  endtask

  task automatic strobe(int kind, int idx);
    @(negedge clk);
    case (kind)
      0: wrap_pulse[idx] = 1'b1;
      1: cap_pulse[idx] = 1'b1;
      default: match_pulse[idx] = 1'b1;
    endcase
    @(negedge clk);
    wrap_pulse = '0; cap_pulse = '0; match_pulse = '0;
  endtask

  task automatic do_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic do_write(logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic clear_all();
    do_read();
    do_write(16'h0000);
  endtask

  task automatic t_reset();
    check("R1 flags after reset", rd_data, 16'h0000);
    check("R1 irq after reset", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_wrap();
    strobe(0, 1);
    check("R3 R2 wrap ch1 at bit 9", rd_data, 16'h0001 << wrap_bit(1));
    check("R11 irq not yet", {15'b0, irq}, 16'h0000);
    @(negedge clk);
    check("R11 irq one cycle later", {15'b0, irq}, 16'h0001);
    strobe(0, 2);
    check("R2 wrap ch2 at bit 14", rd_data, 16'h4200);
    clear_all();
    check("R8 read then write 0 clears", rd_data, 16'h0000);
    @(negedge clk);
    check("R11 irq drops", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_write_ones();
    do_write(16'hFFFF);
    check("R7 R2 writing ones sets nothing", rd_data, 16'h0000);
  endtask

  task automatic t_modes();
    set_mode(0, 0, 2'b00);
    strobe(2, 0);
    check("R4 match ignored in capture mode", rd_data, 16'h0000);
    strobe(1, 0);
    check("R4 capture sets ch0 reg0", rd_data, 16'h0001 << gr_bit(0, 0));
    clear_all();
    set_mode(1, 1, 2'b01);
    strobe(1, 5);
    check("R5 capture ignored in compare mode", rd_data, 16'h0000);
    strobe(2, 5);
    check("R5 match sets ch1 reg1 at bit 6", rd_data, 16'h0040);
    clear_all();
    set_mode(2, 3, 2'b10);
    strobe(1, 11);
    check("R6 capture ignored in pwm mode", rd_data, 16'h0000);
    strobe(2, 11);
    check("R6 match sets ch2 reg3 at bit 13", rd_data, 16'h2000);
    clear_all();
    set_mode(2, 2, 2'b11);
    strobe(1, 10);
    strobe(2, 10);
    check("R6 idle mode ignores both", rd_data, 16'h0000);
  endtask

  task automatic t_unarmed();
    strobe(1, 0);
    do_write(16'h0000);
    check("R8 unread flag survives write 0", rd_data, 16'h0001);
    clear_all();
    do_read();
    strobe(1, 0);
    do_write(16'h0000);
    check("R8 read of 0 arms nothing", rd_data, 16'h0001);
    clear_all();
  endtask

  task automatic t_arm_consumed();
    strobe(1, 0);
    do_read();
    do_write(16'hFFFF);
    check("R7 armed flag written 1 stays", rd_data, 16'h0001);
    do_write(16'h0000);
    check("R9 write consumed the arm", rd_data, 16'h0001);
    clear_all();
    check("R8 re-read then clear", rd_data, 16'h0000);
  endtask

  task automatic t_set_wins();
    strobe(1, 0);
    do_read();
    @(negedge clk);
    wr_en = 1'b1; wr_data = 16'h0000; cap_pulse[0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cap_pulse = '0;
    check("R10 set beats clear", rd_data, 16'h0001);
    do_write(16'h0000);
    check("R9 arm gone after collision", rd_data, 16'h0001);
    clear_all();
  endtask

  task automatic t_comb_read();
    @(negedge clk); cap_pulse[0] = 1'b1;
    @(posedge clk); #1;
    cap_pulse = '0;
    check("R12 flag visible same cycle", rd_data, 16'h0001);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wrap();
    t_write_ones();
    t_modes();
    t_unarmed();
    t_arm_consumed();
    t_set_wins();
    t_comb_read();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #2_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule